// File: doc/BRIEF.md
# Pipelined Fixed-Point Dot-Product Adder Tree

This block forms the inner product of two signed vectors with 26 elements each, a weight vector and an activation vector. Both vectors arrive side by side on wide parallel buses and are taken in on a one-cycle start strobe. One signed multiplier per lane works on its element pair, all of them in the same cycle. A binary adder tree then folds the 26 products into one 32-bit sum. Each level of the tree ends in a register, and so does the multiplier stage, so a new vector pair can be accepted on every cycle.

The operands are signed fixed-point values with 16 bits and 10 fractional bits. Products and the sum keep 20 fractional bits in a 32-bit word, so no shifting or rounding is needed anywhere. A valid flag travels through the pipeline beside each sum. When a sum reaches the end of the tree, it is pushed into a downstream output FIFO through a write strobe, which is held back while that FIFO reports full. While a finished sum waits for space, the whole pipeline freezes. The block sits between operand-loading logic and a result FIFO in a neural-network accelerator. It has no activation function and no pooling.

Top module: `dotp_tree`

## Requirements
- R1: Each lane forms the full signed product of its 16-bit activation and 16-bit weight (two's complement, 10 fractional bits each) as a 32-bit value with 20 fractional bits, with no shift and no rounding. For example, 1.0 × 1.0 (1024 × 1024) gives 0x00100000.
- R2: `sum_o` equals the sum of all 26 lane products. Lane i occupies bits [16i+15:16i] of each operand bus.
- R3: With `ofifo_full_i` low, a start sampled at rising edge k makes `sum_vld_o` high, with the matching sum, after edge k+5. This is the sixth edge counting edge k itself.
- R4: Starts on consecutive cycles each produce exactly one result. The results appear on consecutive cycles, in the order the starts were given.
- R5: `sum_vld_o` is high only for cycles that carry a result of an accepted start. It is never high for idle cycles.
- R6: `ofifo_wr_o` is high exactly when `sum_vld_o` is high and `ofifo_full_i` is low.
- R7: While `sum_vld_o` and `ofifo_full_i` are both high, every pipeline stage holds its contents. The waiting sum stays on `sum_o`. Once full drops, the held results come out in order, with none lost and none repeated.
- R8: A start that arrives during such a stall cycle is not accepted and never produces a result.
- R9: Overflow of the 32-bit sum is not flagged. The sum wraps modulo 2^32 in two's complement; for example, 26 lanes of (−32768) × (−32768) give 0x80000000.
- R10: While reset is asserted, `sum_vld_o` and `ofifo_wr_o` are low and `sum_o` is zero.
- R11: At a tree level with an odd number of terms, the unpaired last term goes to the next level unchanged through that level's register. The last lane therefore reaches the sum with its correct value.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Accept the operand buses this cycle |
| act_vec_i | input | 416 | 26 signed 16-bit activations, lane 0 in the low bits |
| wgt_vec_i | input | 416 | 26 signed 16-bit weights, lane 0 in the low bits |
| ofifo_full_i | input | 1 | Output FIFO has no free entry |
| sum_o | output | 32 | Dot product, 20 fractional bits |
| sum_vld_o | output | 1 | `sum_o` holds a result |
| ofifo_wr_o | output | 1 | Push `sum_o` into the output FIFO |

## Verification
A single corrupted lane or a lost odd-term pass-through shows up as a wrong `sum_o` on the one result that used it, six edges after its start. Vectors that load only the last lane, or only the first lane, isolate each path through the tree. A valid bit that is dropped, duplicated or skewed against its data shows up at once as a missing, extra or misordered strobe in a back-to-back burst. A stage that keeps moving during a stall, or a start taken while stalled, is seen within one or two cycles after full is released: a sum is skipped, repeated or out of order, or a phantom result appears.

// File: rtl/dotp_pkg.sv
package dotp_pkg;

  // Number of terms present at tree level lvl (level 0 = the products).
  function automatic int lane_count(input int lanes, input int lvl);
    return (lanes + (1 << lvl) - 1) >> lvl;
  endfunction

endpackage

// File: rtl/dotp_mul_stage.sv
module dotp_mul_stage #(
  parameter int LANES = 26,
  parameter int OP_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      adv_i,
  input  logic                      start_i,
  input  logic [LANES*OP_W-1:0]     act_i,
  input  logic [LANES*OP_W-1:0]     wgt_i,
  output logic [LANES*2*OP_W-1:0]   prod_o,
  output logic                      vld_o
);
  localparam int PW = 2 * OP_W;

  logic [LANES*PW-1:0] prod_d;

  // Next state: one signed multiplier per lane, operands sign-extended to PW.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] w_ext;
    logic signed [PW-1:0] p;
    assign a_ext = {{OP_W{act_i[i*OP_W+OP_W-1]}}, act_i[i*OP_W +: OP_W]};
    assign w_ext = {{OP_W{wgt_i[i*OP_W+OP_W-1]}}, wgt_i[i*OP_W +: OP_W]};
    assign p     = a_ext * w_ext;
    assign prod_d[i*PW +: PW] = p;
  end

  // Register: enabled only when the pipeline advances.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_o <= '0;
      vld_o  <= 1'b0;
    end else if (adv_i) begin
      prod_o <= prod_d;
      vld_o  <= start_i;
    end
  end

  AST_STALL_HOLD_MUL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(prod_o) && (vld_o == $past(vld_o)))); // R8
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && start_i) |=> vld_o); // R3

endmodule

// File: rtl/dotp_add_level.sv
module dotp_add_level #(
  parameter int N_IN = 26,
  parameter int W    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        adv_i,
  input  logic                        vld_i,
  input  logic [N_IN*W-1:0]           din_i,
  output logic [((N_IN+1)/2)*W-1:0]   sum_o,
  output logic                        vld_o
);
  localparam int N_OUT = (N_IN + 1) / 2;

  logic [N_OUT*W-1:0] sum_d;

  // Next state: pairwise wrapping adds; an unpaired last term passes as is.
  for (genvar j = 0; j < N_OUT; j++) begin : g_pair
    if (2*j + 1 < N_IN) begin : g_add
      assign sum_d[j*W +: W] = din_i[2*j*W +: W] + din_i[(2*j+1)*W +: W];
    end else begin : g_pass
      assign sum_d[j*W +: W] = din_i[2*j*W +: W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o <= '0;
      vld_o <= 1'b0;
    end else if (adv_i) begin
      sum_o <= sum_d;
      vld_o <= vld_i;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && vld_i) |=> vld_o); // R4
  AST_BUBBLE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !vld_i) |=> !vld_o); // R5

  if (N_IN % 2 == 1) begin : g_odd_chk
    AST_ODD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && vld_i) |=>
        (sum_o[N_OUT*W-1 -: W] == $past(din_i[N_IN*W-1 -: W]))); // R11
  end

endmodule

// File: rtl/dotp_tree.sv
module dotp_tree #(
  parameter int LANES = 26,
  parameter int OP_W  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [LANES*OP_W-1:0] act_vec_i,
  input  logic [LANES*OP_W-1:0] wgt_vec_i,
  input  logic                  ofifo_full_i,
  output logic [2*OP_W-1:0]     sum_o,
  output logic                  sum_vld_o,
  output logic                  ofifo_wr_o
);
  localparam int PW     = 2 * OP_W;
  localparam int LEVELS = $clog2(LANES);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic              adv;
  logic [LANES*PW-1:0] prod_bus;
  logic              prod_vld;

  dotp_mul_stage #(.LANES(LANES), .OP_W(OP_W)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_core_n),
    .adv_i   (adv),
    .start_i (start_i),
    .act_i   (act_vec_i),
    .wgt_i   (wgt_vec_i),
    .prod_o  (prod_bus),
    .vld_o   (prod_vld)
  );

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int NI = dotp_pkg::lane_count(LANES, l);
    localparam int NO = dotp_pkg::lane_count(LANES, l + 1);
    logic [NI*PW-1:0] din;
    logic             vin;
    logic [NO*PW-1:0] dout;
    logic             vout;
    if (l == 0) begin : g_first
      assign din = prod_bus;
      assign vin = prod_vld;
    end else begin : g_rest
      assign din = g_lvl[l-1].dout;
      assign vin = g_lvl[l-1].vout;
    end
    dotp_add_level #(.N_IN(NI), .W(PW)) u_lvl (
      .clk_i  (clk_i),
      .rst_ni (rst_core_n),
      .adv_i  (adv),
      .vld_i  (vin),
      .din_i  (din),
      .sum_o  (dout),
      .vld_o  (vout)
    );
  end

  assign sum_o      = g_lvl[LEVELS-1].dout;
  assign sum_vld_o  = g_lvl[LEVELS-1].vout;
  // Global stall: a finished sum that cannot be written freezes every stage.
  assign adv        = !(sum_vld_o && ofifo_full_i);
  assign ofifo_wr_o = sum_vld_o && !ofifo_full_i;

  AST_OUT_HELD: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    (sum_vld_o && ofifo_full_i) |=> (sum_vld_o && $stable(sum_o))); // R7
  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_core_n)
    ofifo_full_i |-> !ofifo_wr_o); // R6

endmodule

// File: tb/sim_dotp_tree.sv
module sim_dotp_tree;
  localparam int LANES = 26;
  localparam int OP_W  = 16;
  localparam int PW    = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, full;
  logic signed [OP_W-1:0] av [LANES];
  logic signed [OP_W-1:0] wv [LANES];
  logic [LANES*OP_W-1:0] act_bus, wgt_bus;
  logic [PW-1:0] sum;
  logic vld, wr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int unsigned seed = 32'h1234_5678;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      act_bus[i*OP_W +: OP_W] = av[i];
      wgt_bus[i*OP_W +: OP_W] = wv[i];
    end
  end

  dotp_tree #(.LANES(LANES), .OP_W(OP_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .act_vec_i(act_bus), .wgt_vec_i(wgt_bus), .ofifo_full_i(full),
    .sum_o(sum), .sum_vld_o(vld), .ofifo_wr_o(wr)
  );

  task automatic check(input string req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [PW-1:0] model();
    longint acc = 0;
    for (int i = 0; i < LANES; i++) acc += longint'(av[i]) * longint'(wv[i]);
    return acc[PW-1:0];
  endfunction

  function automatic logic signed [OP_W-1:0] rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[30:15];
  endfunction

  task automatic clear_vec();
    for (int i = 0; i < LANES; i++) begin av[i] = '0; wv[i] = '0; end
  endtask

  task automatic fill_random();
    for (int i = 0; i < LANES; i++) begin av[i] = rnd16(); wv[i] = rnd16(); end
  endtask

  // Pulse start once, wait exactly five more edges, check the sum.
  task automatic fire_and_check(input string req, input logic [PW-1:0] exp);
    start = 1'b1;
    step();
    start = 1'b0;
    repeat (5) step();
    check(req, "valid at sixth edge", {31'd0, vld}, 32'd1);
    check(req, "sum", sum, exp);
  endtask

  task automatic t_reset();
    check("R10", "valid in reset", {31'd0, vld}, 32'd0);
    check("R10", "write in reset", {31'd0, wr}, 32'd0);
    check("R10", "sum in reset", sum, 32'd0);
  endtask

  task automatic t_latency();
    logic [PW-1:0] exp;
    for (int i = 0; i < LANES; i++) begin
      av[i] = OP_W'((i - 13) * 40);
      wv[i] = OP_W'((i * 7 - 50) * 3);
    end
    exp = model();
    start = 1'b1;
    step();
    start = 1'b0;
    for (int c = 0; c <= 7; c++) begin
      check((c == 5) ? "R3" : "R5", $sformatf("valid after edge k+%0d", c),
            {31'd0, vld}, (c == 5) ? 32'd1 : 32'd0);
      if (c == 5) begin
        check("R2", "patterned sum", sum, exp);
        check("R6", "write when valid and not full", {31'd0, wr}, 32'd1);
      end else begin
        check("R6", "no write when idle", {31'd0, wr}, 32'd0);
      end
      step();
    end
  endtask

  task automatic t_lanes();
    clear_vec();
    av[25] = 16'sd1024; wv[25] = 16'sd1024;
    fire_and_check("R11", 32'h0010_0000);
    clear_vec();
    av[0] = -16'sd512; wv[0] = 16'sd256;
    fire_and_check("R1", 32'hFFFE_0000);
    clear_vec();
    av[24] = 16'sd3; wv[24] = -16'sd5; av[25] = 16'sd7; wv[25] = 16'sd11;
    fire_and_check("R11", 32'd62);
    step();
  endtask

  task automatic t_wrap();
    for (int i = 0; i < LANES; i++) begin av[i] = -16'sd32768; wv[i] = -16'sd32768; end
    fire_and_check("R9", 32'h8000_0000);
    for (int i = 0; i < LANES; i++) begin av[i] = 16'sd32767; wv[i] = 16'sd32767; end
    fire_and_check("R9", model());
    step();
  endtask

  task automatic t_back_to_back();
    logic [PW-1:0] exp [4];
    for (int j = 0; j < 4; j++) begin
      fill_random();
      exp[j] = model();
      start = 1'b1;
      step();
    end
    start = 1'b0;
    step();
    step();
    for (int j = 0; j < 4; j++) begin
      check("R4", $sformatf("burst valid %0d", j), {31'd0, vld}, 32'd1);
      check("R4", $sformatf("burst sum %0d", j), sum, exp[j]);
      check("R6", $sformatf("burst write %0d", j), {31'd0, wr}, 32'd1);
      step();
    end
    check("R5", "valid after burst", {31'd0, vld}, 32'd0);
  endtask

  task automatic t_stall();
    logic [PW-1:0] ea, eb;
    full = 1'b1;
    fill_random(); ea = model(); start = 1'b1; step();
    fill_random(); eb = model(); step();
    start = 1'b0;
    repeat (4) step();
    check("R7", "stalled valid", {31'd0, vld}, 32'd1);
    check("R6", "no write while full", {31'd0, wr}, 32'd0);
    check("R7", "stalled sum", sum, ea);
    fill_random();
    start = 1'b1;
    step();
    start = 1'b0;
    for (int c = 0; c < 3; c++) begin
      check("R7", "held sum", sum, ea);
      check("R7", "held valid", {31'd0, vld}, 32'd1);
      step();
    end
    full = 1'b0;
    #1;
    check("R6", "write on release", {31'd0, wr}, 32'd1);
    check("R7", "first result on release", sum, ea);
    step();
    check("R7", "second result valid", {31'd0, vld}, 32'd1);
    check("R7", "second result", sum, eb);
    step();
    for (int c = 0; c < 8; c++) begin
      check("R8", "no result from start during stall", {31'd0, vld}, 32'd0);
      step();
    end
  endtask

  task automatic t_random();
    for (int n = 0; n < 3; n++) begin
      fill_random();
      fire_and_check("R2", model());
      step();
    end
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    full  = 1'b0;
    clear_vec();
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    repeat (4) step();
    t_latency();
    t_lanes();
    t_wrap();
    t_back_to_back();
    t_stall();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule